// File: doc/BRIEF.md
# Frame Transmit Engine with Backoff, FCS and Acknowledgement Timeout

This block is the transmit engine of a wireless LAN MAC accelerator. Software streams one frame into a single on-chip buffer and then issues a start command. The engine then waits for the medium to be free. The medium counts as busy when the external channel-busy input is high or when the internal network allocation vector (NAV) is nonzero. While the medium is free, the engine counts down a random backoff in whole slots.

When the backoff ends, the engine streams the payload to the PHY, followed at once by a CRC-32 frame check sequence that it computes while the bytes go out. If the frame expects an acknowledgement, a microsecond timer opens a response window. The result reaches software only through three status bits: done, success and timeout.

Both byte streams use valid/ready handshakes. A byte moves on a rising clock edge where valid and ready are both high. The engine never withdraws or changes an offered PHY byte while `tx_ready` is low, so the PHY may stall it for any number of cycles. The load side applies back-pressure by holding `in_ready` low while a frame is held. A source must keep its byte until it sees ready.

Top module: `wlan_tx_engine`

## Requirements
- R1: After reset, all three status bits are 0, `in_ready` is 1, `tx_valid` is 0 and `engine_busy` is 0.
- R2: The buffer holds a single frame. `in_ready` is high only while the buffer is empty. A frame closes on a byte with `in_last`, or on the DEPTH-th byte (default 64) whatever `in_last` says. The frame is kept until its last FCS byte is sent. A `start` pulse has no effect when the buffer is empty or when `engine_busy` is high.
- R3: An accepted start loads the backoff count with a pseudo-random value ANDed with `cw_mask`. A slot is SLOT_US (default 9) consecutive microsecond ticks of free medium. At each slot end, a count of zero starts transmission; otherwise the count drops by one. With `cw_mask` = 0 and a free medium, the first byte is offered between (SLOT_US-1)·CLK_PER_US+1 and SLOT_US·CLK_PER_US cycles after the start edge (CLK_PER_US defaults to 4).
- R4: A busy medium during backoff discards the partial slot and freezes the backoff count. No byte is offered while it stays busy.
- R5: A `nav_valid` pulse sets the NAV to the larger of its current value and `nav_us`. The NAV drops by one on every microsecond tick until it reaches zero, and the medium is busy while it is nonzero.
- R6: The PHY stream carries the payload bytes in load order, then four FCS bytes. `tx_last` is high only on the final FCS byte. An offered byte, together with its `tx_last`, holds steady while `tx_ready` is low.
- R7: The FCS is CRC-32 with polynomial 0x04C11DB7, processed bit-reflected. It starts from all ones, covers the payload, is complemented, and is sent least significant byte first. The payload "123456789" gives 0xCBF43926.
- R8: A frame that does not need an acknowledgement sets done and success in the cycle after its last FCS byte is taken.
- R9: For a frame that needs an acknowledgement, a response timer starts after its last FCS byte and counts microsecond ticks. An `ack_rx` pulse inside the window sets done and success in the next cycle. Otherwise the ACK_TIMEOUT-th tick (`ack_timeout_us`) sets done and timeout. Whenever done is set, exactly one of success and timeout is set.
- R10: An `ack_rx` pulse that arrives while no response window is open does not change the status.
- R11: An accepted start clears done, success and timeout in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load byte valid |
| in_data | input | 8 | Load byte |
| in_last | input | 1 | Final byte of the frame being loaded |
| in_ready | output | 1 | Buffer can take a byte |
| start | input | 1 | Frame-start command |
| need_ack | input | 1 | Frame expects an acknowledgement (sampled at start) |
| cw_mask | input | CW_W | Contention window mask (sampled at start) |
| ack_timeout_us | input | TMR_W | Response window in microseconds (sampled at start) |
| chan_busy | input | 1 | Carrier sensed busy |
| nav_valid | input | 1 | Load a NAV reservation |
| nav_us | input | NAV_W | Reservation length in microseconds |
| tx_valid | output | 1 | PHY byte valid |
| tx_data | output | 8 | PHY byte |
| tx_last | output | 1 | Final FCS byte |
| tx_ready | input | 1 | PHY takes the byte |
| ack_rx | input | 1 | Acknowledgement received pulse |
| st_done | output | 1 | Status: frame finished |
| st_success | output | 1 | Status: delivered |
| st_timeout | output | 1 | Status: no acknowledgement in time |
| engine_busy | output | 1 | A frame is in progress |

## Verification
The results arrive at different times. The start-clear, the no-acknowledgement done bit and an accepted acknowledgement all show up one cycle after their cause. The first PHY byte and a timeout depend on the free-running microsecond tick, so they land in windows one tick period wide. The bench drives inputs on falling edges and samples there. It counts cycles from the causing edge and checks one-cycle results at exactly the next falling edge. The tick-bound results are checked against the lower and upper bounds of their window, with the slot, NAV and busy time added in. Bytes are logged only on falling edges where valid and the bench's own ready are both high.

// File: rtl/wtx_pkg.sv
package wtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_BACKOFF = 3'd1,
    ST_SEND    = 3'd2,
    ST_FCS     = 3'd3,
    ST_ACK     = 3'd4
  } tx_state_e;

  // One byte of the reflected CRC-32 (polynomial 0x04C11DB7 reversed).
  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/wtx_us_tick.sv
module wtx_us_tick #(
  parameter int CLK_PER_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/wtx_lfsr.sv
module wtx_lfsr #(
  parameter int          LFSR_W = 16,
  parameter int          OUT_W  = 10,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [LFSR_W-1:0] q;

  // Galois form, taps 16,14,13,11.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= LFSR_W'(SEED);
    end else begin
      q <= (q >> 1) ^ (q[0] ? LFSR_W'(16'hB400) : '0);
    end
  end

  assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/wtx_frame_buf.sv
module wtx_frame_buf #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             wr_last,
  output logic             wr_ready,
  input  logic             release_i,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic [LEN_W-1:0] frame_len,
  output logic             full
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             full_q;
  logic             wr_go;

  assign wr_go = wr_valid && !full_q;

  always_ff @(posedge clk) begin
    if (wr_go) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      len_q    <= '0;
      full_q   <= 1'b0;
    end else if (release_i) begin
      full_q   <= 1'b0;
      wr_ptr_q <= '0;
    end else if (wr_go) begin
      if (wr_last || wr_ptr_q == TOP) begin
        full_q   <= 1'b1;
        len_q    <= {1'b0, wr_ptr_q} + 1'b1;
        wr_ptr_q <= '0;
      end else begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
    end
  end

  assign wr_ready  = !full_q;
  assign rd_data   = mem[rd_addr];
  assign frame_len = len_q;
  assign full      = full_q;
endmodule

// File: rtl/wtx_crc32.sv
module wtx_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] fcs
);
  import wtx_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= crc32_step(crc_q, data);
    end
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/wlan_tx_engine.sv
module wlan_tx_engine
  import wtx_pkg::*;
#(
  parameter int          DEPTH      = 64,
  parameter int          CLK_PER_US = 4,
  parameter int          SLOT_US    = 9,
  parameter int          CW_W       = 10,
  parameter int          NAV_W      = 16,
  parameter int          TMR_W      = 32,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             start,
  input  logic             need_ack,
  input  logic [CW_W-1:0]  cw_mask,
  input  logic [TMR_W-1:0] ack_timeout_us,
  input  logic             chan_busy,
  input  logic             nav_valid,
  input  logic [NAV_W-1:0] nav_us,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  input  logic             ack_rx,
  output logic             st_done,
  output logic             st_success,
  output logic             st_timeout,
  output logic             engine_busy
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int LEN_W  = PTR_W + 1;
  localparam int SLOT_W = $clog2(SLOT_US + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_US - 1);

  tx_state_e        state_q;
  logic             us_tick;
  logic [CW_W-1:0]  rnd;
  logic [CW_W-1:0]  bo_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PTR_W-1:0] rd_q;
  logic [1:0]       fcs_idx_q;
  logic [TMR_W-1:0] ack_tmr_q;
  logic [TMR_W-1:0] ack_to_q;
  logic             need_ack_q;
  logic [NAV_W-1:0] nav_q;
  logic [NAV_W-1:0] nav_dec;
  logic             medium_busy;
  logic             start_acc;
  logic             beat;
  logic             last_payload;
  logic             frame_done;
  logic             ack_expire;
  logic             buf_full;
  logic [7:0]       buf_byte;
  logic [LEN_W-1:0] frame_len;
  logic [31:0]      fcs;
  logic             crc_en;

  wtx_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(us_tick)
  );

  wtx_lfsr #(.LFSR_W(16), .OUT_W(CW_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  wtx_frame_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_data(in_data), .wr_last(in_last), .wr_ready(in_ready),
    .release_i(frame_done), .rd_addr(rd_q), .rd_data(buf_byte),
    .frame_len(frame_len), .full(buf_full)
  );

  assign crc_en = beat && (state_q == ST_SEND);

  wtx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .init(start_acc), .en(crc_en),
    .data(buf_byte), .fcs(fcs)
  );

  // Medium state and reservation vector
  assign medium_busy = chan_busy || (nav_q != '0);
  assign nav_dec     = (us_tick && nav_q != '0) ? nav_q - 1'b1 : nav_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nav_q <= '0;
    end else if (nav_valid && nav_us > nav_dec) begin
      nav_q <= nav_us;
    end else begin
      nav_q <= nav_dec;
    end
  end

  // Handshake and sequencing terms
  assign start_acc    = start && (state_q == ST_IDLE) && buf_full;
  assign beat         = tx_valid && tx_ready;
  assign last_payload = (({1'b0, rd_q} + 1'b1) == frame_len);
  assign frame_done   = beat && (state_q == ST_FCS) && (fcs_idx_q == 2'd3);
  assign ack_expire   = (state_q == ST_ACK) && us_tick && !ack_rx &&
                        (({1'b0, ack_tmr_q} + 1'b1) >= {1'b0, ack_to_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bo_q       <= '0;
      slot_q     <= '0;
      rd_q       <= '0;
      fcs_idx_q  <= '0;
      ack_tmr_q  <= '0;
      ack_to_q   <= '0;
      need_ack_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            state_q    <= ST_BACKOFF;
            bo_q       <= rnd & cw_mask;
            slot_q     <= '0;
            rd_q       <= '0;
            fcs_idx_q  <= '0;
            need_ack_q <= need_ack;
            ack_to_q   <= ack_timeout_us;
          end
        end
        ST_BACKOFF: begin
          if (medium_busy) begin
            slot_q <= '0;
          end else if (us_tick) begin
            if (slot_q == SLOT_LAST) begin
              slot_q <= '0;
              if (bo_q == '0) begin
                state_q <= ST_SEND;
              end else begin
                bo_q <= bo_q - 1'b1;
              end
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (beat) begin
            if (last_payload) begin
              state_q   <= ST_FCS;
              fcs_idx_q <= '0;
            end else begin
              rd_q <= rd_q + 1'b1;
            end
          end
        end
        ST_FCS: begin
          if (beat) begin
            if (fcs_idx_q == 2'd3) begin
              state_q   <= need_ack_q ? ST_ACK : ST_IDLE;
              ack_tmr_q <= '0;
            end else begin
              fcs_idx_q <= fcs_idx_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (ack_rx || ack_expire) begin
            state_q <= ST_IDLE;
          end else if (us_tick) begin
            ack_tmr_q <= ack_tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Status bits seen by software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_done    <= 1'b0;
      st_success <= 1'b0;
      st_timeout <= 1'b0;
    end else if (start_acc) begin
      st_done    <= 1'b0;
      st_success <= 1'b0;
      st_timeout <= 1'b0;
    end else if ((frame_done && !need_ack_q) || (state_q == ST_ACK && ack_rx)) begin
      st_done    <= 1'b1;
      st_success <= 1'b1;
    end else if (ack_expire) begin
      st_done    <= 1'b1;
      st_timeout <= 1'b1;
    end
  end

  // PHY byte stream
  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    tx_last  = 1'b0;
    if (state_q == ST_SEND) begin
      tx_valid = 1'b1;
      tx_data  = buf_byte;
    end else if (state_q == ST_FCS) begin
      tx_valid = 1'b1;
      tx_data  = fcs[8*fcs_idx_q +: 8];
      tx_last  = (fcs_idx_q == 2'd3);
    end
  end

  assign engine_busy = (state_q != ST_IDLE);
endmodule

// File: rtl/wtx_checker.sv
module wtx_checker
  import wtx_pkg::*;
#(
  parameter int CW_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input tx_state_e       state,
  input logic            medium_busy,
  input logic [CW_W-1:0] bo,
  input logic            start_acc,
  input logic            in_ready,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [7:0]      tx_data,
  input logic            tx_last,
  input logic            ack_rx,
  input logic            st_done,
  input logic            st_success,
  input logic            st_timeout
);
  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKOFF || state == ST_SEND || state == ST_FCS) |-> !in_ready); // R2

  AST_TX_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(!medium_busy)); // R3

  AST_BO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKOFF && medium_busy) |=> $stable(bo) && state == ST_BACKOFF); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R6

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> $onehot({st_success, st_timeout})); // R9

  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_done |-> !st_success && !st_timeout); // R9

  AST_LATE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rx && state == ST_IDLE && !start_acc) |=>
      $stable({st_done, st_success, st_timeout})); // R10

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !st_done); // R11
endmodule

bind wlan_tx_engine wtx_checker #(.CW_W(CW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .medium_busy(medium_busy),
  .bo(bo_q), .start_acc(start_acc), .in_ready(in_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .ack_rx(ack_rx), .st_done(st_done), .st_success(st_success), .st_timeout(st_timeout)
);

// File: tb/wlan_tx_engine_bench.sv
module wlan_tx_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int C   = 4;
  localparam int S   = 9;
  localparam int T   = 10;
  localparam int DEP = 64;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] base;
    logic [7:0] step;
    logic       ack_req;
    logic       bp;
    logic [7:0] ack_us;
    logic       exp_ok;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{8'd1,  8'h5A, 8'd0, 1'b0, 1'b0, 8'd0,  1'b1},
    '{8'd16, 8'h00, 8'd1, 1'b1, 1'b0, 8'd3,  1'b1},
    '{8'd9,  8'h31, 8'd1, 1'b0, 1'b1, 8'd0,  1'b1},
    '{8'd5,  8'hF0, 8'd3, 1'b1, 1'b1, 8'd0,  1'b0},
    '{8'd7,  8'h80, 8'd7, 1'b1, 1'b0, 8'd15, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, start = 1'b0, need_ack = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [9:0]  cw_mask = '0;
  logic [31:0] ack_timeout_us = 32'(T);
  logic        chan_busy = 1'b0, nav_valid = 1'b0, tx_ready = 1'b1, ack_rx = 1'b0;
  logic [15:0] nav_us = '0;
  logic        in_ready, tx_valid, tx_last, st_done, st_success, st_timeout, engine_busy;
  logic [7:0]  tx_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cap [256];
  int  ncap;
  int  last_pos;
  bit  busy_leak;

  always #(CLK_PERIOD/2) clk = ~clk;

  wlan_tx_engine u_wlan_tx_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .start(start), .need_ack(need_ack), .cw_mask(cw_mask),
    .ack_timeout_us(ack_timeout_us), .chan_busy(chan_busy), .nav_valid(nav_valid),
    .nav_us(nav_us), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .ack_rx(ack_rx), .st_done(st_done), .st_success(st_success),
    .st_timeout(st_timeout), .engine_busy(engine_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int len, input logic [7:0] base,
                                          input logic [7:0] step, input bit ovf);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      c ^= {24'd0, 8'(base + 8'(i) * step)};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    if (ovf) c = c;
    return ~c;
  endfunction

  task automatic load(input int len, input logic [7:0] base, input logic [7:0] step,
                      input bit mark_last, output int acc);
    acc = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(base + 8'(i) * step);
      in_last  = mark_last && (i == len - 1);
      if (in_ready) acc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run(input bit bp, input int busy_cyc, input int nav_len, output int lat);
    bit seen = 1'b0;
    bit fin  = 1'b0;
    @(negedge clk);
    start = 1'b1;
    if (nav_len > 0) begin
      nav_valid = 1'b1;
      nav_us    = 16'(nav_len);
    end
    @(negedge clk);
    start     = 1'b0;
    nav_valid = 1'b0;
    chan_busy = (busy_cyc > 0);
    ncap = 0; lat = -1; last_pos = -1; busy_leak = 1'b0;
    for (int k = 1; k < 6000 && !fin; k++) begin
      if (k > busy_cyc) chan_busy = 1'b0;
      tx_ready = bp ? k[0] : 1'b1;
      if (tx_valid && !seen) begin
        seen = 1'b1;
        lat  = k;
      end
      if (tx_valid && k <= busy_cyc) busy_leak = 1'b1;
      if (tx_valid && tx_ready) begin
        cap[ncap] = tx_data;
        if (tx_last) begin
          if (last_pos < 0) last_pos = ncap;
          fin = 1'b1;
        end
        ncap++;
      end
      @(negedge clk);
    end
    tx_ready = 1'b1;
  endtask

  function automatic logic [31:0] cap_fcs(input int len);
    return {cap[len+3], cap[len+2], cap[len+1], cap[len]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : main
    int acc, lat, e;
    bit pay_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({st_done, st_success, st_timeout} == 3'b000, "R1", "status", {st_done, st_success, st_timeout}, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(tx_valid == 1'b0 && engine_busy == 1'b0, "R1", "idle", {tx_valid, engine_busy}, 0);

    // R2 start with empty buffer is ignored
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    chk(engine_busy == 1'b0 && tx_valid == 1'b0, "R2", "start on empty buffer", {engine_busy, tx_valid}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      cw_mask  = '0;
      need_ack = VEC[v].ack_req;
      load(int'(VEC[v].len), VEC[v].base, VEC[v].step, 1'b1, acc);
      chk(acc == int'(VEC[v].len), "R2", "bytes accepted", acc, VEC[v].len);
      chk(in_ready == 1'b0, "R2", "in_ready while frame held", in_ready, 0);
      run(VEC[v].bp, 0, 0, lat);
      if (v == 0)
        chk(lat >= (S-1)*C+1 && lat <= S*C, "R3", "first byte latency, mask 0", lat, S*C);
      chk(ncap == int'(VEC[v].len) + 4, "R6", "beats sent", ncap, VEC[v].len + 4);
      chk(last_pos == int'(VEC[v].len) + 3, "R6", "tx_last position", last_pos, VEC[v].len + 3);
      pay_ok = 1'b1;
      for (int i = 0; i < int'(VEC[v].len); i++)
        if (cap[i] != 8'(VEC[v].base + 8'(i) * VEC[v].step)) pay_ok = 1'b0;
      chk(pay_ok, "R6", "payload order", pay_ok, 1);
      chk(cap_fcs(int'(VEC[v].len)) == ref_fcs(int'(VEC[v].len), VEC[v].base, VEC[v].step, 1'b0),
          "R7", "fcs", cap_fcs(int'(VEC[v].len)), ref_fcs(int'(VEC[v].len), VEC[v].base, VEC[v].step, 1'b0));
      if (v == 2)
        chk(cap_fcs(9) == 32'hCBF43926, "R7", "check string fcs", cap_fcs(9), 32'hCBF43926);
      if (!VEC[v].ack_req) begin
        chk(st_done && st_success && !st_timeout, "R8", "done+success after last byte",
            {st_done, st_success, st_timeout}, 3'b110);
      end else if (VEC[v].ack_us != 0 && int'(VEC[v].ack_us) < T) begin
        e = 1;
        while (e < int'(VEC[v].ack_us) * C) begin @(negedge clk); e++; end
        chk(!st_done, "R9", "window open before ack", st_done, 0);
        ack_rx = 1'b1;
        @(negedge clk); ack_rx = 1'b0;
        chk(st_done && st_success && !st_timeout, "R9", "ack in window",
            {st_done, st_success, st_timeout}, 3'b110);
      end else begin
        e = 1;
        while (!st_done && e < 2000) begin @(negedge clk); e++; end
        chk(st_done && st_timeout && !st_success, "R9", "timeout status",
            {st_done, st_success, st_timeout}, 3'b101);
        chk(e >= (T-1)*C+1 && e <= T*C, "R9", "timeout cycle", e, T*C);
        if (VEC[v].ack_us != 0) begin
          while (e < int'(VEC[v].ack_us) * C) begin @(negedge clk); e++; end
          ack_rx = 1'b1;
          @(negedge clk); ack_rx = 1'b0;
          @(negedge clk);
          chk(st_done && st_timeout && !st_success, "R10", "late ack ignored",
              {st_done, st_success, st_timeout}, 3'b101);
        end
      end
      chk((st_success == VEC[v].exp_ok), "R9", "final outcome", st_success, VEC[v].exp_ok);
    end

    // R11 start clears status in the next cycle
    need_ack = 1'b0;
    load(3, 8'h10, 8'd1, 1'b1, acc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!st_done && !st_success && engine_busy, "R11", "status cleared",
        {st_done, st_success, engine_busy}, 3'b001);
    e = 0;
    while (!st_done && e < 2000) begin @(negedge clk); e++; end

    // R10 ack while idle has no effect on a finished frame
    ack_rx = 1'b1;
    @(negedge clk); ack_rx = 1'b0;
    @(negedge clk);
    chk(st_done && st_success && !st_timeout, "R10", "idle ack ignored",
        {st_done, st_success, st_timeout}, 3'b110);

    // R3 with a nonzero contention window
    cw_mask = 10'd3;
    load(4, 8'h22, 8'd5, 1'b1, acc);
    run(1'b0, 0, 0, lat);
    chk(lat >= (S-1)*C+1 && lat <= 4*S*C, "R3", "latency within 4 slots", lat, 4*S*C);

    // R4 busy carrier freezes the backoff
    cw_mask = '0;
    load(4, 8'h44, 8'd1, 1'b1, acc);
    run(1'b0, 150, 0, lat);
    chk(!busy_leak, "R4", "no byte while busy", busy_leak, 0);
    chk(lat >= 150 + (S-1)*C - 1 && lat <= 150 + S*C + 2, "R4", "latency after busy", lat, 150 + S*C);

    // R5 NAV reservation holds the medium
    load(4, 8'h66, 8'd1, 1'b1, acc);
    run(1'b0, 0, 30, lat);
    chk(lat >= (30+S-1)*C+1 && lat <= (30+S)*C, "R5", "latency after NAV", lat, (30+S)*C);

    // R2 overflow: frame closes at DEPTH bytes without in_last
    load(DEP + 6, 8'h01, 8'd1, 1'b0, acc);
    chk(acc == DEP, "R2", "bytes accepted on overflow", acc, DEP);
    run(1'b0, 0, 0, lat);
    chk(ncap == DEP + 4, "R2", "beats of full frame", ncap, DEP + 4);
    chk(cap_fcs(DEP) == ref_fcs(DEP, 8'h01, 8'd1, 1'b1), "R7", "fcs of full frame",
        cap_fcs(DEP), ref_fcs(DEP, 8'h01, 8'd1, 1'b1));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule